// File: doc/BRIEF.md
# Sticky Interrupt Register Bank with Read-Clear

This block holds the per-port interrupt flags of a multi-port repeater controller. There are three two-byte flag registers. The first records partition changes, the second records short frames received with a good checksum, and the third records link-test changes on the twisted-pair ports. The port logic drives the partition and link inputs as levels, and the block detects their transitions itself. Short-frame events arrive as single-cycle pulses. A flag can set only where its companion enable bit is 1. Once set, a flag stays set until the host reads the byte that holds it.

The host uses a byte-wide register port. Writing the value 0x01 to the bank-select register opens this bank. Only then can the host read or clear the flag bytes and read or write the enable bytes. A status byte is readable in any bank; its bit 0 is the OR of every flag. The registered output `int_o` follows that OR one cycle later. It drops only once every flag in every register is zero.

Top module: `irq_bank_top`

## Requirements
- R1: After reset, every flag bit and every enable bit is 0, the bank-select register is 0x00, `int_o` is 0 and `rdata_o` is 0x00. The level-tracking history is 0, which means not partitioned and link failing.
- R2: Address 0x00 is the bank-select register. Its value reads back and is written directly. The flag bytes (0x10..0x15) and enable bytes (0x18..0x1D) are reachable only while it holds 0x01. When it holds any other value, reads of those addresses return 0x00 and clear nothing, and writes to them are ignored.
- R3: A flag bit can set only in a cycle where its enable bit is 1. Events on a disabled bit are lost.
- R4: Partition flag register (0x10 low byte, 0x11 high byte). A change of `part_state_i[n]` in either direction sets bit n. Bits 0..11 are ports 0..11, bit 12 is the AUI port and bit 13 is the reverse-AUI port.
- R5: Link flag register (0x14, 0x15). A change of `link_pass_i[n]` in either direction, pass to fail or fail to pass, sets bit n for twisted-pair port n (0..11).
- R6: Short-frame flag register (0x12, 0x13). A pulse on `runt_evt_i[n]` sets bit n. The bit order is the partition order plus bit 14 for the expansion port.
- R7: A read with `rd_en_i` high returns the addressed byte on `rdata_o` in the next cycle and clears only that byte. When no read is made, `rdata_o` is 0x00.
- R8: If an enabled event arrives in the same cycle that its byte is read, the read returns the old value and the bit stays set.
- R9: Status address 0x01 returns the OR of all flags in bit 0, in any bank. `int_o` (active high) equals that OR as it stood one cycle earlier.
- R10: `int_o` stays high while any flag in any register is set. It drops only after all flags are clear.
- R11: Host writes to flag addresses have no effect on the flags.
- R12: Enable bytes 0x18/0x19, 0x1A/0x1B and 0x1C/0x1D belong to the partition, short-frame and link registers. Bits with no port read as 0, so the high bytes read 0x3F, 0x7F and 0x0F when all ones are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 8 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered host read data |
| part_state_i | input | 14 | Partition state per port (1 = partitioned) |
| runt_evt_i | input | 15 | Short-frame-with-good-checksum pulses |
| link_pass_i | input | 12 | Link-test state per twisted-pair port (1 = pass) |
| int_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an enabled event that lands in the same cycle as the read that clears its byte. This case decides whether an event is lost. The bench first sets the short-frame bit. It then raises the read strobe and the same pulse together on one falling edge. It reads the byte again to prove the bit survived, and once more to prove that the next read clears it. The drop of `int_o` is driven the same way. Two registers hold flags at once, and they are drained one at a time, with `int_o` checked after each read.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 3;
  localparam logic [7:0] ADDR_BANK     = 8'h00;
  localparam logic [7:0] ADDR_STAT     = 8'h01;
  localparam logic [7:0] ADDR_IRQ_BASE = 8'h10;
  localparam logic [7:0] ADDR_EN_BASE  = 8'h18;
  localparam logic [7:0] BANK_IRQ      = 8'h01;
  // register index order, fixed by address decode
  localparam int IDX_PART = 0;
  localparam int IDX_RUNT = 1;
  localparam int IDX_LINK = 2;
endpackage

// File: rtl/irq_change_det.sv
module irq_change_det #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= state_i;
  end

  assign chg_o = state_i ^ prev_q;
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg
  import irq_bank_pkg::*;
#(
  parameter int W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             clr_lo_i,
  input  logic             clr_hi_i,
  input  logic             en_wr_lo_i,
  input  logic             en_wr_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] en_o
);
  logic [W-1:0] stat_q, en_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam bit HI = (i >= 8);
    logic clr, wr;
    assign clr = HI ? clr_hi_i : clr_lo_i;
    assign wr  = HI ? en_wr_hi_i : en_wr_lo_i;

    // set after clear: a same-cycle event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        stat_q[i] <= (stat_q[i] & ~clr) | (set_i[i] & en_q[i]);
        if (wr) en_q[i] <= wdata_i[i % 8];
      end
    end
  end

  if (W < REG_W) begin : g_pad
    assign stat_o = {{(REG_W-W){1'b0}}, stat_q};
    assign en_o   = {{(REG_W-W){1'b0}}, en_q};
  end else begin : g_nopad
    assign stat_o = stat_q;
    assign en_o   = en_q;
  end
endmodule

// File: rtl/irq_host_if.sv
module irq_host_if
  import irq_bank_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             rd_en_i,
  input  logic [7:0]                       addr_i,
  input  logic [7:0]                       wdata_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0]   stat_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0]   en_i,
  input  logic                             any_i,
  output logic                             bank_sel_o,
  output logic [NUM_REGS-1:0]              clr_lo_o,
  output logic [NUM_REGS-1:0]              clr_hi_o,
  output logic [NUM_REGS-1:0]              en_wr_lo_o,
  output logic [NUM_REGS-1:0]              en_wr_hi_o,
  output logic [7:0]                       rdata_o
);
  localparam logic [7:0] SPAN = 8'(2 * NUM_REGS);

  logic [7:0] bank_q, rdata_q, rd_d;
  logic [7:0] irq_off, en_off;
  logic       irq_hit, en_hit;

  assign bank_sel_o = (bank_q == BANK_IRQ);
  assign irq_off    = addr_i - ADDR_IRQ_BASE;
  assign en_off     = addr_i - ADDR_EN_BASE;
  assign irq_hit    = bank_sel_o && (addr_i >= ADDR_IRQ_BASE) && (irq_off < SPAN);
  assign en_hit     = bank_sel_o && (addr_i >= ADDR_EN_BASE) && (en_off < SPAN);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    logic irq_sel, en_sel;
    assign irq_sel       = irq_hit && (irq_off[7:1] == 7'(r));
    assign en_sel        = en_hit && (en_off[7:1] == 7'(r));
    assign clr_lo_o[r]   = rd_en_i && irq_sel && !irq_off[0];
    assign clr_hi_o[r]   = rd_en_i && irq_sel && irq_off[0];
    assign en_wr_lo_o[r] = wr_en_i && en_sel && !en_off[0];
    assign en_wr_hi_o[r] = wr_en_i && en_sel && en_off[0];
  end

  always_comb begin
    rd_d = 8'h00;
    if (addr_i == ADDR_BANK)      rd_d = bank_q;
    else if (addr_i == ADDR_STAT) rd_d = {7'b0, any_i};
    else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (irq_hit && irq_off[7:1] == 7'(r))
          rd_d = irq_off[0] ? stat_i[r][15:8] : stat_i[r][7:0];
        if (en_hit && en_off[7:1] == 7'(r))
          rd_d = en_off[0] ? en_i[r][15:8] : en_i[r][7:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      rdata_q <= rd_en_i ? rd_d : 8'h00;
      if (wr_en_i && addr_i == ADDR_BANK) bank_q <= wdata_i;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int NUM_TP = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_TP+1:0]   part_state_i,
  input  logic [NUM_TP+2:0]   runt_evt_i,
  input  logic [NUM_TP-1:0]   link_pass_i,
  output logic                int_o
);
  localparam int PART_W = NUM_TP + 2;
  localparam int RUNT_W = NUM_TP + 3;
  localparam int LINK_W = NUM_TP;

  logic [PART_W-1:0] part_chg;
  logic [LINK_W-1:0] link_chg;
  logic [NUM_REGS-1:0][REG_W-1:0] set_vec, stat, en;
  logic [NUM_REGS*REG_W-1:0] stat_flat, en_flat;
  logic [NUM_REGS-1:0] clr_lo, clr_hi, en_wr_lo, en_wr_hi;
  logic any_set, int_q, bank_sel;

  irq_change_det #(.W(PART_W)) u_part_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(part_state_i), .chg_o(part_chg));

  irq_change_det #(.W(LINK_W)) u_link_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(link_pass_i), .chg_o(link_chg));

  assign set_vec[IDX_PART] = REG_W'(part_chg);
  assign set_vec[IDX_RUNT] = REG_W'(runt_evt_i);
  assign set_vec[IDX_LINK] = REG_W'(link_chg);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int W = (r == IDX_PART) ? PART_W : (r == IDX_RUNT) ? RUNT_W : LINK_W;
    irq_sticky_reg #(.W(W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec[r]),
      .clr_lo_i(clr_lo[r]), .clr_hi_i(clr_hi[r]),
      .en_wr_lo_i(en_wr_lo[r]), .en_wr_hi_i(en_wr_hi[r]),
      .wdata_i(wdata_i), .stat_o(stat[r]), .en_o(en[r]));
  end

  assign stat_flat = stat;
  assign en_flat   = en;
  assign any_set   = |stat_flat;

  irq_host_if u_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .stat_i(stat), .en_i(en),
    .any_i(any_set), .bank_sel_o(bank_sel), .clr_lo_o(clr_lo), .clr_hi_o(clr_hi),
    .en_wr_lo_o(en_wr_lo), .en_wr_hi_o(en_wr_hi), .rdata_o(rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b0;
    else         int_q <= any_set;
  end

  assign int_o = int_q;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int SW = 48
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic [7:0]    addr_i,
  input logic [7:0]    rdata_o,
  input logic          int_o,
  input logic [SW-1:0] stat_i,
  input logic [SW-1:0] en_i,
  input logic          sel_i
);
  assert_int_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> int_o == $past(|stat_i));

  assert_enable_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_i & ~$past(stat_i) & ~$past(en_i)) == '0);

  assert_clear_by_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((~stat_i & $past(stat_i)) == '0) || $past(rd_en_i)));

  assert_idle_rdata_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == 8'h00);

  assert_unselected_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !sel_i && addr_i >= 8'h10) |=> rdata_o == 8'h00);
endmodule

bind irq_bank_top irq_bank_chk #(.SW(irq_bank_pkg::NUM_REGS * irq_bank_pkg::REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .int_o(int_o), .stat_i(stat_flat), .en_i(en_flat),
  .sel_i(bank_sel));

// File: tb/tb_irq_bank_top.sv
`timescale 1ns/1ps
module tb_irq_bank_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [13:0] part = '0;
  logic [14:0] runt = '0;
  logic [11:0] link = '0;
  logic [7:0] rdata_o;
  logic int_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  irq_bank_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .part_state_i(part), .runt_evt_i(runt),
    .link_pass_i(link), .int_o(int_o));

  // reference model
  logic [15:0] m_stat[3], m_en[3], ns[3];
  logic [15:0] msk[3];
  logic [7:0] m_bank, m_rdata, rdv;
  logic [13:0] m_prev_part;
  logic [11:0] m_prev_link;
  logic m_int, m_any, m_sel;
  int idx;

  initial begin
    msk[0] = 16'h3FFF; msk[1] = 16'h7FFF; msk[2] = 16'h0FFF;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin m_stat[k] = '0; m_en[k] = '0; end
      m_bank = 0; m_rdata = 0; m_int = 0; m_prev_part = 0; m_prev_link = 0;
    end else begin
      m_any = (m_stat[0] | m_stat[1] | m_stat[2]) != 0;
      m_sel = (m_bank == 8'h01);
      for (int k = 0; k < 3; k++) ns[k] = m_stat[k];
      rdv = 8'h00;
      if (rd) begin
        if (addr == 8'h00) rdv = m_bank;
        else if (addr == 8'h01) rdv = {7'b0, m_any};
        else if (m_sel && addr >= 8'h10 && addr < 8'h16) begin
          idx = (addr - 8'h10) / 2;
          if (addr[0]) begin rdv = m_stat[idx][15:8]; ns[idx][15:8] = 0; end
          else         begin rdv = m_stat[idx][7:0];  ns[idx][7:0]  = 0; end
        end else if (m_sel && addr >= 8'h18 && addr < 8'h1E) begin
          idx = (addr - 8'h18) / 2;
          rdv = addr[0] ? m_en[idx][15:8] : m_en[idx][7:0];
        end
      end
      ns[0] = ns[0] | ({2'b0, part ^ m_prev_part} & m_en[0]);
      ns[1] = ns[1] | ({1'b0, runt} & m_en[1]);
      ns[2] = ns[2] | ({4'b0, link ^ m_prev_link} & m_en[2]);
      if (wr) begin
        if (addr == 8'h00) m_bank = wdata;
        else if (m_sel && addr >= 8'h18 && addr < 8'h1E) begin
          idx = (addr - 8'h18) / 2;
          if (addr[0]) m_en[idx][15:8] = wdata & msk[idx][15:8];
          else         m_en[idx][7:0]  = wdata & msk[idx][7:0];
        end
      end
      for (int k = 0; k < 3; k++) m_stat[k] = ns[k];
      m_int = m_any; m_rdata = rdv;
      m_prev_part = part; m_prev_link = link;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    chk({phase, " rdata"}, rdata_o, m_rdata);
    chk({phase, " int"}, {7'b0, int_o}, {7'b0, m_int});
    rd = 0; wr = 0; runt = '0;
  endtask

  task automatic host_wr(logic [7:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic host_rd(logic [7:0] a, logic [7:0] exp, string tag);
    rd = 1; addr = a; cyc(); chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 int", {7'b0, int_o}, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
    rst_n = 1'b1;
    host_rd(8'h01, 8'h00, "R1 status");
    host_rd(8'h00, 8'h00, "R1 bank");

    phase = "R2";
    host_wr(8'h18, 8'hFF);
    part = 14'h0001; cyc();
    host_rd(8'h10, 8'h00, "R2 unselected read");
    host_wr(8'h00, 8'h01);
    host_rd(8'h00, 8'h01, "R2 bank readback");
    host_rd(8'h18, 8'h00, "R2 enable write ignored");
    host_rd(8'h10, 8'h00, "R3 disabled event lost");

    phase = "R3";
    host_wr(8'h18, 8'h02);
    part = part ^ 14'h0006; cyc();
    host_rd(8'h10, 8'h02, "R3 only enabled bit");

    phase = "R12";
    for (int a = 8'h18; a < 8'h1E; a++) host_wr(8'(a), 8'hFF);
    host_rd(8'h19, 8'h3F, "R12 part enable hi");
    host_rd(8'h1B, 8'h7F, "R12 runt enable hi");
    host_rd(8'h1D, 8'h0F, "R12 link enable hi");

    phase = "R4";
    part = part | 14'h1000; cyc();
    part = part & ~14'h1000; cyc();
    host_rd(8'h11, 8'h10, "R4 AUI both directions");
    part = part & ~14'h0001; cyc();
    host_rd(8'h10, 8'h01, "R4 reconnect");

    phase = "R6";
    runt = 15'h4000; cyc();
    host_rd(8'h13, 8'h40, "R6 expansion bit");
    runt = 15'h2001; cyc();
    host_rd(8'h12, 8'h01, "R6 port0");
    host_rd(8'h13, 8'h20, "R6 reverse AUI");

    phase = "R5";
    link = 12'h801; cyc();
    host_rd(8'h14, 8'h01, "R5 fail to pass");
    link = 12'h000; cyc();
    host_rd(8'h14, 8'h01, "R5 pass to fail");
    host_rd(8'h15, 8'h08, "R5 port11");

    phase = "R11";
    runt = 15'h0004; cyc();
    host_wr(8'h12, 8'h00);
    host_rd(8'h12, 8'h04, "R11 write no clear");
    host_wr(8'h14, 8'hFF);
    host_rd(8'h14, 8'h00, "R11 write no set");

    phase = "R8";
    runt = 15'h0008; cyc();
    runt = 15'h0008; rd = 1; addr = 8'h12; cyc();
    chk("R8 read old value", rdata_o, 8'h08);
    host_rd(8'h12, 8'h08, "R8 event kept");
    host_rd(8'h12, 8'h00, "R7 cleared");

    phase = "R10";
    part = part ^ 14'h0010; link = link ^ 12'h010; cyc();
    cyc();
    chk("R9 int set", {7'b0, int_o}, 8'h01);
    host_rd(8'h10, 8'h10, "R10 first reg");
    cyc();
    chk("R10 int held", {7'b0, int_o}, 8'h01);
    host_rd(8'h01, 8'h01, "R9 status set");
    host_rd(8'h14, 8'h10, "R10 second reg");
    cyc();
    chk("R10 int dropped", {7'b0, int_o}, 8'h00);
    host_rd(8'h01, 8'h00, "R9 status clear");

    phase = "R7";
    part = part ^ 14'h0101; cyc();
    host_rd(8'h10, 8'h01, "R7 low byte");
    host_rd(8'h11, 8'h01, "R7 high byte untouched");

    phase = "R2";
    runt = 15'h0020; cyc();
    host_wr(8'h00, 8'h02);
    host_rd(8'h12, 8'h00, "R2 deselected read");
    host_wr(8'h00, 8'h01);
    host_rd(8'h12, 8'h20, "R2 no clear while deselected");
    cyc();

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule